// File: doc/BRIEF.md
# Programmable Interrupt Controller Core

This block collects eight interrupt request lines, arbitrates between them by fixed priority, and signals the processor. Software talks to it through a byte-wide register window with two addresses, selected by `a0_i`. A short initialization sequence places the block in a known state. It sets the vector base, the cascade configuration byte and whether end-of-interrupt is automatic. After that, odd-address writes load the interrupt mask, and even-address writes are commands: specific or non-specific end-of-interrupt, and the choice of which status register an even-address read returns.

When the processor pulses `inta_i`, the block answers with a vector byte on `vector_o`. The vector is formed from the upper five bits of the programmed base and the three-bit number of the winning line. The winning request moves into the in-service register, unless automatic end-of-interrupt was chosen. If the request disappeared before the acknowledge, the block answers with the line-7 vector and marks nothing in service. A new request reaches the processor only when it outranks everything already in service, which gives nested service with line 0 as the highest priority.

Top module: `pic_core`

## Requirements
- R1: After reset the mask register reads 0xFF at the odd address, an even-address read returns the request register and reads 0x00, `int_o` is low and `cas_cfg_o` is 0x00.
- R2: An even-address write with bit 4 set starts initialization. The next odd-address writes are taken, in order, as the vector base, the cascade byte and, only if bit 0 of the starting byte was 1, the mode word. These writes do not change the mask. The cascade byte is presented on `cas_cfg_o`.
- R3: An acknowledged line n returns `vector_o` = {base[7:3], n[2:0]}, valid from the cycle after the `inta_i` cycle.
- R4: Line 0 has the highest priority and line 7 the lowest. `int_o` is high only when some unmasked request has a lower index than every bit set in the in-service register.
- R5: After initialization, an odd-address write loads the mask, where bit n = 1 masks line n. An odd-address read returns the mask.
- R6: A request bit is set by a rising edge on its line and clears when the line falls. A line that stays high does not raise a new request after it has been acknowledged.
- R7: In normal mode (mode word bit 1 = 0), an acknowledge clears the request bit and sets the in-service bit of the winner. In automatic mode (mode word bit 1 = 1), no in-service bit is set.
- R8: An even-address write of 0x60+n clears in-service bit n and no other bit.
- R9: An even-address write of 0x20 clears the lowest-index bit that is set in the in-service register.
- R10: An even-address write of 0x0B makes even-address reads return the in-service register. 0x0A switches them back to the request register. Starting initialization also selects the request register.
- R11: An acknowledge while `int_o` is low returns the vector {base[7:3], 3'b111} and sets no in-service bit.
- R12: Before the first initialization completes, `int_o` stays low. Initialization without a mode word completes after the cascade byte, in normal end-of-interrupt mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe, one cycle per byte |
| a0_i | input | 1 | Register address: 0 even, 1 odd |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the address on `a0_i` (combinational) |
| irq_line_i | input | 8 | Edge-triggered request lines, bit n is line n |
| inta_i | input | 1 | Acknowledge strobe, one cycle |
| int_o | output | 1 | Interrupt request toward the processor |
| vector_o | output | 8 | Vector byte captured on the acknowledge |
| cas_cfg_o | output | 8 | Stored cascade configuration byte |

## Verification
The priority resolver is driven with all 255 non-empty patterns of simultaneous rising lines. Each pattern shows whether the lowest index wins, whether the remaining lines are held back by the new in-service bit, and whether they are released by a non-specific end-of-interrupt. All 256 mask values are swept with every line rising at once. This separates correct masking from plain priority, and the all-masked case exercises the spurious line-7 answer. All 32 vector bases are combined with each of the eight lines, which catches any mixing of base and line-number bits. Directed sequences cover nested service, the difference between specific and non-specific end-of-interrupt, a request that vanishes before acknowledge, automatic end-of-interrupt, and initialization without a mode word.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int BYTE_W = 8;
  localparam int N_IR   = BYTE_W;
  localparam int IDX_W  = $clog2(N_IR);
  localparam int BASE_W = BYTE_W - IDX_W;

  localparam logic [BYTE_W-1:0] CMD_SEL_ISR  = 8'h0B;
  localparam logic [BYTE_W-1:0] CMD_SEL_IRR  = 8'h0A;
  localparam logic [BYTE_W-1:0] CMD_EOI_ANY  = 8'h20;
  localparam logic [BASE_W-1:0] CMD_EOI_SPEC = 5'b01100;
  localparam int INIT_BIT = 4;

  typedef enum logic [1:0] {
    ST_READY,
    ST_BASE,
    ST_CAS,
    ST_MODE
  } init_st_e;
endpackage

// File: rtl/pic_prio.sv
module pic_prio
  import pic_pkg::*;
#(
  parameter int N = N_IR,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  oh_o,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  for (genvar i = 0; i < N; i++) begin : g_oh
    if (i == 0) begin : g_first
      assign oh_o[i] = req_i[i];
    end else begin : g_rest
      assign oh_o[i] = req_i[i] & ~|req_i[i-1:0];
    end
  end

  assign any_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (oh_o[i]) idx_o = idx_o | IW'(i);
    end
  end
endmodule

// File: rtl/pic_req.sv
module pic_req
  import pic_pkg::*;
#(
  parameter int N = N_IR
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] irr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= line_i;
      // held bits drop with the line; fresh edges latch
      irr_q  <= (irr_q & line_i & ~clr_i) | (line_i & ~prev_q);
    end
  end

  assign irr_o = irr_q;
endmodule

// File: rtl/pic_cfg.sv
module pic_cfg
  import pic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              a0_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] imr_o,
  output logic [BASE_W-1:0] vbase_o,
  output logic [BYTE_W-1:0] cas_o,
  output logic              aeoi_o,
  output logic              init_done_o,
  output logic              rsel_isr_o,
  output logic              init_start_o,
  output logic              eoi_spec_o,
  output logic              eoi_any_o,
  output logic [IDX_W-1:0]  eoi_idx_o
);
  init_st_e          st_q;
  logic              need_mode_q;
  logic [BYTE_W-1:0] imr_q, cas_q;
  logic [BASE_W-1:0] vbase_q;
  logic              aeoi_q, done_q, rsel_q;
  logic              cmd_wr;

  assign init_start_o = wr_i & ~a0_i & wdata_i[INIT_BIT];
  assign cmd_wr       = wr_i & ~a0_i & ~wdata_i[INIT_BIT] & (st_q == ST_READY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_READY;
      need_mode_q <= 1'b0;
      imr_q       <= '1;
      cas_q       <= '0;
      vbase_q     <= '0;
      aeoi_q      <= 1'b0;
      done_q      <= 1'b0;
      rsel_q      <= 1'b0;
    end else if (init_start_o) begin
      st_q        <= ST_BASE;
      need_mode_q <= wdata_i[0];
      aeoi_q      <= 1'b0;
      done_q      <= 1'b0;
      rsel_q      <= 1'b0;
    end else if (wr_i && a0_i) begin
      unique case (st_q)
        ST_BASE: begin
          vbase_q <= wdata_i[BYTE_W-1:IDX_W];
          st_q    <= ST_CAS;
        end
        ST_CAS: begin
          cas_q <= wdata_i;
          if (need_mode_q) begin
            st_q <= ST_MODE;
          end else begin
            st_q   <= ST_READY;
            done_q <= 1'b1;
          end
        end
        ST_MODE: begin
          aeoi_q <= wdata_i[1];
          st_q   <= ST_READY;
          done_q <= 1'b1;
        end
        default: imr_q <= wdata_i;
      endcase
    end else if (cmd_wr) begin
      if (wdata_i == CMD_SEL_ISR) rsel_q <= 1'b1;
      else if (wdata_i == CMD_SEL_IRR) rsel_q <= 1'b0;
    end
  end

  assign eoi_spec_o  = cmd_wr & done_q & (wdata_i[BYTE_W-1:IDX_W] == CMD_EOI_SPEC);
  assign eoi_any_o   = cmd_wr & done_q & (wdata_i == CMD_EOI_ANY);
  assign eoi_idx_o   = wdata_i[IDX_W-1:0];
  assign imr_o       = imr_q;
  assign vbase_o     = vbase_q;
  assign cas_o       = cas_q;
  assign aeoi_o      = aeoi_q;
  assign init_done_o = done_q;
  assign rsel_isr_o  = rsel_q;
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              a0_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [N_IR-1:0]   irq_line_i,
  input  logic              inta_i,
  output logic              int_o,
  output logic [BYTE_W-1:0] vector_o,
  output logic [BYTE_W-1:0] cas_cfg_o
);
  logic [N_IR-1:0]   imr_q, irr_q, isr_q, isr_d;
  logic [BASE_W-1:0] vbase_q;
  logic              aeoi_q, init_done_q, rsel_isr;
  logic              init_start, eoi_spec, eoi_any;
  logic [IDX_W-1:0]  eoi_idx;
  logic [N_IR-1:0]   pending, pend_oh, svc_oh, irr_clr, isr_set, eoi_clr;
  logic              pend_any, svc_any, grant_ok, ack_grant;
  logic [IDX_W-1:0]  pend_idx, svc_idx;
  logic [BYTE_W-1:0] vector_q;

  pic_cfg u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_i),
    .a0_i         (a0_i),
    .wdata_i      (wdata_i),
    .imr_o        (imr_q),
    .vbase_o      (vbase_q),
    .cas_o        (cas_cfg_o),
    .aeoi_o       (aeoi_q),
    .init_done_o  (init_done_q),
    .rsel_isr_o   (rsel_isr),
    .init_start_o (init_start),
    .eoi_spec_o   (eoi_spec),
    .eoi_any_o    (eoi_any),
    .eoi_idx_o    (eoi_idx)
  );

  pic_req #(.N(N_IR)) u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (irq_line_i),
    .clr_i  (irr_clr),
    .irr_o  (irr_q)
  );

  assign pending = irr_q & ~imr_q & {N_IR{init_done_q}};

  pic_prio #(.N(N_IR)) u_pend_prio (
    .req_i (pending),
    .oh_o  (pend_oh),
    .any_o (pend_any),
    .idx_o (pend_idx)
  );

  pic_prio #(.N(N_IR)) u_svc_prio (
    .req_i (isr_q),
    .oh_o  (svc_oh),
    .any_o (svc_any),
    .idx_o (svc_idx)
  );

  // a request must outrank every in-service level
  assign grant_ok  = pend_any & (~svc_any | (pend_idx < svc_idx));
  assign ack_grant = inta_i & grant_ok;
  assign irr_clr   = ack_grant ? pend_oh : '0;
  assign isr_set   = (ack_grant && !aeoi_q) ? pend_oh : '0;

  always_comb begin
    eoi_clr = '0;
    if (eoi_spec)     eoi_clr[eoi_idx] = 1'b1;
    else if (eoi_any) eoi_clr = svc_oh;
  end

  assign isr_d = init_start ? '0 : ((isr_q & ~eoi_clr) | isr_set);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q    <= '0;
      vector_q <= '0;
    end else begin
      isr_q <= isr_d;
      if (inta_i) vector_q <= {vbase_q, (ack_grant ? pend_idx : {IDX_W{1'b1}})};
    end
  end

  assign int_o    = grant_ok;
  assign vector_o = vector_q;
  assign rdata_o  = a0_i ? imr_q : (rsel_isr ? isr_q : irr_q);
endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk
  import pic_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              inta_i,
  input logic              int_o,
  input logic [BYTE_W-1:0] vector_o,
  input logic [N_IR-1:0]   imr_q,
  input logic [N_IR-1:0]   irr_q,
  input logic [N_IR-1:0]   isr_q,
  input logic [BASE_W-1:0] vbase_q,
  input logic              aeoi_q,
  input logic              init_done_q
);
  assert_int_before_init_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_q |-> !int_o);

  assert_int_unmasked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((irr_q & ~imr_q) != '0));

  assert_isr_only_on_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inta_i |=> ((isr_q & ~$past(isr_q)) == '0));

  assert_aeoi_no_isr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aeoi_q |=> ((isr_q & ~$past(isr_q)) == '0));

  assert_vector_base_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i |=> (vector_o[BYTE_W-1:IDX_W] == $past(vbase_q)));

  assert_spurious_vec_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !int_o) |=> ((vector_o[IDX_W-1:0] == {IDX_W{1'b1}}) && ($countones(isr_q) <= $countones($past(isr_q)))));
endmodule

bind pic_core pic_core_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .inta_i      (inta_i),
  .int_o       (int_o),
  .vector_o    (vector_o),
  .imr_q       (imr_q),
  .irr_q       (irr_q),
  .isr_q       (isr_q),
  .vbase_q     (vbase_q),
  .aeoi_q      (aeoi_q),
  .init_done_q (init_done_q)
);

// File: tb/pic_core_test.sv
module pic_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;

  logic       clk, rst_n, wr, a0, inta;
  logic [7:0] wdata, lines;
  logic [7:0] rdata, vec, cas;
  logic       irq;
  int         n_run, n_fail, cyc;
  bit         done;

  pic_core uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_i       (wr),
    .a0_i       (a0),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .irq_line_i (lines),
    .inta_i     (inta),
    .int_o      (irq),
    .vector_o   (vec),
    .cas_cfg_o  (cas)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic adr, input logic [7:0] d);
    wr = 1'b1; a0 = adr; wdata = d;
    step();
    wr = 1'b0; a0 = 1'b0; wdata = 8'h00;
  endtask

  task automatic rd_reg(input logic adr, output logic [7:0] v);
    a0 = adr;
    #1 v = rdata;
    a0 = 1'b0;
  endtask

  task automatic ack();
    inta = 1'b1;
    step();
    inta = 1'b0;
  endtask

  task automatic init4(input logic [7:0] base, input logic [7:0] mode);
    wr_reg(1'b0, 8'h11);
    wr_reg(1'b1, base);
    wr_reg(1'b1, 8'h04);
    wr_reg(1'b1, mode);
  endtask

  function automatic logic [2:0] lowest(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) if (v[i]) lowest = 3'(i);
  endfunction

  function automatic logic [7:0] bitof(input logic [2:0] n);
    return 8'(1) << n;
  endfunction

  initial begin
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > MAX_CYCLES) begin
        n_fail++;
        $display("FAIL watchdog: got %0d cycles expected <= %0d", cyc, MAX_CYCLES);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] v, m, lo;
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; wr = 1'b0; a0 = 1'b0; inta = 1'b0; wdata = '0; lines = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    rd_reg(1'b1, v); chk("R1 mask", v, 8'hFF);
    rd_reg(1'b0, v); chk("R1 irr", v, 8'h00);
    chk("R1 int", {7'd0, irq}, 8'h00);
    chk("R1 cas", cas, 8'h00);

    // R12 no interrupt before initialization
    wr_reg(1'b1, 8'h00);
    lines = 8'h01; step();
    chk("R12 int pre-init", {7'd0, irq}, 8'h00);
    lines = 8'h00; step();

    // R2 sequence leaves mask alone, stores cascade byte
    wr_reg(1'b1, 8'h00);
    wr_reg(1'b0, 8'h11);
    wr_reg(1'b1, 8'h08);
    rd_reg(1'b1, v); chk("R2 mask untouched", v, 8'h00);
    wr_reg(1'b1, 8'h04);
    wr_reg(1'b1, 8'h01);
    chk("R2 cas byte", cas, 8'h04);
    rd_reg(1'b1, v); chk("R2 mask after init", v, 8'h00);

    // R3 all bases x all lines
    for (int b = 0; b < 32; b++) begin
      init4(8'(b << 3), 8'h01);
      wr_reg(1'b0, 8'h0B);
      for (int n = 0; n < 8; n++) begin
        lines = bitof(3'(n)); step();
        chk("R3 int", {7'd0, irq}, 8'h01);
        ack();
        chk("R3 vector", vec, 8'((b << 3) | n));
        wr_reg(1'b0, 8'(8'h60 + n));
        rd_reg(1'b0, v); chk("R8 isr cleared", v, 8'h00);
        lines = 8'h00; step();
      end
    end

    // R4/R9 every non-empty simultaneous pattern
    init4(8'h00, 8'h01);
    wr_reg(1'b0, 8'h0B);
    for (int p = 1; p < 256; p++) begin
      lines = 8'(p); step();
      chk("R4 int", {7'd0, irq}, 8'h01);
      ack();
      lo = {5'd0, lowest(8'(p))};
      chk("R4 winner", vec, lo);
      rd_reg(1'b0, v); chk("R7 isr set", v, bitof(lo[2:0]));
      chk("R4 blocked by isr", {7'd0, irq}, 8'h00);
      wr_reg(1'b0, 8'h20);
      chk("R9 released", {7'd0, irq}, {7'd0, ((8'(p) & ~bitof(lo[2:0])) != 0)});
      lines = 8'h00; step();
      chk("R6 falling clears", {7'd0, irq}, 8'h00);
    end

    // R5/R11 every mask with all lines rising
    for (int mm = 0; mm < 256; mm++) begin
      m = 8'(mm);
      wr_reg(1'b1, m);
      rd_reg(1'b1, v); chk("R5 mask read", v, m);
      lines = 8'hFF; step();
      chk("R5 int", {7'd0, irq}, {7'd0, (m != 8'hFF)});
      ack();
      if (m == 8'hFF) begin
        chk("R11 spurious vector", vec, 8'h07);
        rd_reg(1'b0, v); chk("R11 no isr", v, 8'h00);
      end else begin
        lo = {5'd0, lowest(~m)};
        chk("R5 vector", vec, lo);
        rd_reg(1'b0, v); chk("R5 isr", v, bitof(lo[2:0]));
      end
      wr_reg(1'b0, 8'h20);
      lines = 8'h00; step();
    end
    wr_reg(1'b1, 8'h00);

    // R6 held line does not retrigger
    lines = 8'h10; step();
    ack();
    chk("R6 first", vec, 8'h04);
    wr_reg(1'b0, 8'h64);
    step();
    chk("R6 held no retrigger", {7'd0, irq}, 8'h00);
    lines = 8'h00; step();

    // R8/R9 nesting
    init4(8'h20, 8'h01);
    lines = 8'h08; step();
    ack(); chk("R4 nest first", vec, 8'h23);
    lines = 8'h28; step();
    chk("R4 lower blocked", {7'd0, irq}, 8'h00);
    lines = 8'h2A; step();
    chk("R4 higher passes", {7'd0, irq}, 8'h01);
    ack(); chk("R4 nest second", vec, 8'h21);
    wr_reg(1'b0, 8'h0B);
    rd_reg(1'b0, v); chk("R7 nested isr", v, 8'h0A);
    wr_reg(1'b0, 8'h63);
    rd_reg(1'b0, v); chk("R8 specific only n", v, 8'h02);
    wr_reg(1'b0, 8'h20);
    rd_reg(1'b0, v); chk("R9 nonspecific", v, 8'h00);
    chk("R4 lower now passes", {7'd0, irq}, 8'h01);
    ack(); chk("R4 third", vec, 8'h25);
    wr_reg(1'b0, 8'h0A);
    rd_reg(1'b0, v); chk("R10 irr view", v, 8'h00);
    wr_reg(1'b0, 8'h0B);
    rd_reg(1'b0, v); chk("R10 isr view", v, 8'h20);
    wr_reg(1'b0, 8'h20);
    lines = 8'h00; step();
    // two bits in service, 0x20 takes the lower index
    lines = 8'h40; step(); ack();
    lines = 8'h44; step(); ack();
    rd_reg(1'b0, v); chk("R9 setup", v, 8'h44);
    wr_reg(1'b0, 8'h20);
    rd_reg(1'b0, v); chk("R9 lowest index", v, 8'h40);
    wr_reg(1'b0, 8'h20);
    lines = 8'h00; step();

    // R11 request vanishes before acknowledge
    lines = 8'h10; step();
    lines = 8'h00; step();
    chk("R11 int gone", {7'd0, irq}, 8'h00);
    ack();
    chk("R11 vector", vec, 8'h27);
    rd_reg(1'b0, v); chk("R11 isr", v, 8'h00);

    // R7 automatic mode
    init4(8'h08, 8'h03);
    rd_reg(1'b0, v); chk("R10 init selects irr", v, 8'h00);
    wr_reg(1'b0, 8'h0B);
    lines = 8'h04; step(); ack();
    chk("R7 aeoi vector", vec, 8'h0A);
    rd_reg(1'b0, v); chk("R7 aeoi isr", v, 8'h00);
    lines = 8'h00; step();

    // R12 no mode word
    wr_reg(1'b0, 8'h10);
    wr_reg(1'b1, 8'h40);
    wr_reg(1'b1, 8'h02);
    chk("R2 slave id", cas, 8'h02);
    wr_reg(1'b1, 8'h5A);
    rd_reg(1'b1, v); chk("R12 mask after short init", v, 8'h5A);
    wr_reg(1'b1, 8'h00);
    wr_reg(1'b0, 8'h0B);
    lines = 8'h02; step(); ack();
    chk("R12 vector", vec, 8'h41);
    rd_reg(1'b0, v); chk("R12 normal eoi mode", v, 8'h02);
    lines = 8'h00; step();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule